// File: doc/BRIEF.md
# Configuration Flash Access Arbiter

This block decides which of three masters drives the shared 16-bit parallel flash bus of a configuration controller: the internal configuration engine that streams an image into an FPGA, the JTAG in-system-programming unit, or an external processor or FPGA on the external flash port. Ownership follows reset-line handshakes and JTAG instruction-update events. There is no request/grant rotation.

A "pending configuration" JTAG instruction update latches a hold that drives the FPGA configuration-reset output low. This puts the controller into reset and stops any internal flash traffic. An "initiate configuration" instruction update later drops the hold, and the FPGA then reloads from the freshly written flash. The JTAG-side strobes and the FPGA reset line arrive asynchronously and pass through a two-stage synchronizer before use. Every handover passes through at least one cycle with no owner and all internal drivers tri-stated.

The state machine has four states. ST_IDLE has no owner. ST_CFG is owned by the configuration engine, ST_JTAG by JTAG programming and ST_EXT by the external port. The transitions are:
- IDLE→JTAG when a programming session is active.
- IDLE→EXT when an external request is present, the controller is in reset and no JTAG session is active.
- IDLE→CFG when configuration is active, the controller is not in reset and no JTAG session is active.
- CFG→IDLE on a JTAG session, on controller reset, or when configuration ends.
- JTAG→IDLE when the session ends.
- EXT→IDLE on a JTAG session, when the request ends, or when the controller leaves reset.

Top module: `cfg_flash_arbiter`

## Requirements
- R1: `owner` encodes the bus master as 00 none, 01 configuration engine, 10 JTAG programming, 11 external. With inputs held steady, the owner settles to a fixed value. It is 10 if a JTAG session is active. Otherwise it is 11 if an external request is present and the controller is in reset. Otherwise it is 01 if configuration is active and the controller is not in reset. Otherwise it is 00.
- R2: While a JTAG session is active, the external port is never granted. When no one owns the bus and a JTAG session is active, JTAG takes the bus on the next cycle, even if an external request is also pending.
- R3: The owner never changes directly from one non-zero code to a different non-zero code. At least one cycle with owner 00 lies between them.
- R4: `ext_grant` is high only while `ctrl_status_n` is low and `int_drv_en` is low. `int_drv_en` is high exactly when the owner is 01 or 10.
- R5: A rising edge of `jtag_pend_upd` sets the hold. `hold_fpga_n` goes low, the controller is in reset (`ctrl_status_n` low), and a configuration-engine ownership ends. If both update strobes rise together, the hold is set.
- R6: A rising edge of `jtag_init_upd` clears the hold (`hold_fpga_n` high). When no hold is set, it has no effect.
- R7: A low level on `fpga_ncfg_in` puts the controller in reset (`ctrl_status_n` low). This frees the bus for an external request.
- R8: JTAG-side inputs and `fpga_ncfg_in` pass two synchronizer flops. A pend strobe applied before a clock edge changes `hold_fpga_n` at the third rising edge, and not earlier.
- R9: After reset, the outputs are owner 00, `int_drv_en` 0, `ext_grant` 0, `hold_fpga_n` 1 and `ctrl_status_n` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jtag_pend_upd | input | 1 | JTAG domain: pending-configuration instruction update strobe |
| jtag_init_upd | input | 1 | JTAG domain: initiate-configuration instruction update strobe |
| jtag_isp_active | input | 1 | JTAG domain: programming session active level |
| fpga_ncfg_in | input | 1 | FPGA configuration-reset line, active low, asynchronous |
| cfg_active | input | 1 | Configuration engine wants the bus |
| ext_req | input | 1 | External flash master requests the bus |
| owner | output | 2 | Current bus owner code |
| int_drv_en | output | 1 | Enable for the internal flash drivers (0 = tri-stated) |
| ext_grant | output | 1 | External port may drive the flash bus |
| hold_fpga_n | output | 1 | Drives the FPGA configuration-reset line low while held |
| ctrl_status_n | output | 1 | Controller status line, low = controller held in reset |

## Verification
The hardest situation to reach is a handover between two different owners. Both the leaving condition and the entering condition must change in the same input step, and the idle cycle lasts only one clock. The bench sweeps every ordered pair of the 16 input combinations, settling on the first and then switching to the second. It compares the settled owner with a value computed from the priority rule, while a per-cycle monitor watches for a direct jump between non-zero owners. The hold path is reached separately by pulsing the pend strobe under configuration ownership and counting edges to its effect.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_CFG  = 2'b01,
        OWN_JTAG = 2'b10,
        OWN_EXT  = 2'b11
    } owner_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CFG,
        ST_JTAG,
        ST_EXT
    } arb_state_e;
endpackage

// File: rtl/cfa_sync.sv
module cfa_sync #(
    parameter int WIDTH   = 1,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfa_hold_ctl.sv
module cfa_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_s,
    input  logic init_s,
    output logic hold
);
    logic pend_d, init_d;
    logic pend_rise, init_rise;

    assign pend_rise = pend_s & ~pend_d;
    assign init_rise = init_s & ~init_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_d <= 1'b0;
            init_d <= 1'b0;
            hold   <= 1'b0;
        end else begin
            pend_d <= pend_s;
            init_d <= init_s;
            if (pend_rise)      hold <= 1'b1;
            else if (init_rise) hold <= 1'b0;
        end
    end
endmodule

// File: rtl/cfa_fsm.sv
module cfa_fsm
    import cfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       isp,
    input  logic       ext_req,
    input  logic       ctrl_rst,
    input  logic       cfg_active,
    output logic [1:0] owner,
    output logic       int_drv_en,
    output logic       ext_grant
);
    arb_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (isp)                         nxt = ST_JTAG;
                else if (ext_req && ctrl_rst)    nxt = ST_EXT;
                else if (cfg_active && !ctrl_rst) nxt = ST_CFG;
            end
            ST_CFG:  if (isp || ctrl_rst || !cfg_active) nxt = ST_IDLE;
            ST_JTAG: if (!isp)                            nxt = ST_IDLE;
            ST_EXT:  if (isp || !ext_req || !ctrl_rst)    nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        owner      = OWN_NONE;
        int_drv_en = 1'b0;
        ext_grant  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CFG:  begin owner = OWN_CFG;  int_drv_en = 1'b1; end
            ST_JTAG: begin owner = OWN_JTAG; int_drv_en = 1'b1; end
            ST_EXT:  begin owner = OWN_EXT;  ext_grant = ctrl_rst; end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfg_flash_arbiter.sv
module cfg_flash_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       jtag_pend_upd,
    input  logic       jtag_init_upd,
    input  logic       jtag_isp_active,
    input  logic       fpga_ncfg_in,
    input  logic       cfg_active,
    input  logic       ext_req,
    output logic [1:0] owner,
    output logic       int_drv_en,
    output logic       ext_grant,
    output logic       hold_fpga_n,
    output logic       ctrl_status_n
);
    localparam int ASYNC_W = 4;
    localparam logic [ASYNC_W-1:0] ASYNC_RST = 4'b0001;

    logic [ASYNC_W-1:0] async_s;
    logic pend_s, init_s, isp_s, ncfg_s;
    logic hold, ctrl_rst;

    cfa_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(ASYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({jtag_pend_upd, jtag_init_upd, jtag_isp_active, fpga_ncfg_in}),
        .q     (async_s)
    );

    assign {pend_s, init_s, isp_s, ncfg_s} = async_s;

    cfa_hold_ctl u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_s (pend_s),
        .init_s (init_s),
        .hold   (hold)
    );

    assign ctrl_rst      = hold | ~ncfg_s;
    assign hold_fpga_n   = ~hold;
    assign ctrl_status_n = ~ctrl_rst;

    cfa_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .isp        (isp_s),
        .ext_req    (ext_req),
        .ctrl_rst   (ctrl_rst),
        .cfg_active (cfg_active),
        .owner      (owner),
        .int_drv_en (int_drv_en),
        .ext_grant  (ext_grant)
    );
endmodule

// File: rtl/cfa_checker.sv
module cfa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       isp_sync,
    input logic [1:0] owner,
    input logic       int_drv_en,
    input logic       ext_grant,
    input logic       hold_fpga_n,
    input logic       ctrl_status_n
);
    AST_NO_DIRECT_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != 2'b00) |=> (owner == $past(owner) || owner == 2'b00)); // R3

    AST_EXT_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ext_grant |-> (!ctrl_status_n && !int_drv_en)); // R4

    AST_JTAG_WINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (isp_sync && owner == 2'b00) |=> (owner == 2'b10)); // R2

    AST_NO_EXT_DURING_ISP: assert property (@(posedge clk) disable iff (!rst_n)
        isp_sync |=> !ext_grant); // R2

    AST_HOLD_MEANS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_fpga_n |-> !ctrl_status_n); // R5

    AST_RESET_ENDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_status_n |=> (owner != 2'b01)); // R7
endmodule

bind cfg_flash_arbiter cfa_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .isp_sync      (isp_s),
    .owner         (owner),
    .int_drv_en    (int_drv_en),
    .ext_grant     (ext_grant),
    .hold_fpga_n   (hold_fpga_n),
    .ctrl_status_n (ctrl_status_n)
);

// File: tb/tb_cfg_flash_arbiter.sv
module tb_cfg_flash_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jtag_pend_upd = 1'b0, jtag_init_upd = 1'b0, jtag_isp_active = 1'b0;
    logic fpga_ncfg_in = 1'b1, cfg_active = 1'b0, ext_req = 1'b0;
    logic [1:0] owner;
    logic int_drv_en, ext_grant, hold_fpga_n, ctrl_status_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] prev_owner = 2'b00;
    bit mon_on = 1'b0;
    int gap_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_flash_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .jtag_pend_upd(jtag_pend_upd), .jtag_init_upd(jtag_init_upd),
        .jtag_isp_active(jtag_isp_active), .fpga_ncfg_in(fpga_ncfg_in),
        .cfg_active(cfg_active), .ext_req(ext_req),
        .owner(owner), .int_drv_en(int_drv_en), .ext_grant(ext_grant),
        .hold_fpga_n(hold_fpga_n), .ctrl_status_n(ctrl_status_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // combo bits: 0 isp, 1 ext_req, 2 fpga reset low, 3 cfg_active
    task automatic apply(input logic [3:0] c);
        jtag_isp_active = c[0];
        ext_req         = c[1];
        fpga_ncfg_in    = ~c[2];
        cfg_active      = c[3];
    endtask

    function automatic int exp_owner(input logic [3:0] c, input bit held);
        bit rst;
        rst = c[2] | held;
        if (c[0])               return 2;
        else if (c[1] && rst)   return 3;
        else if (c[3] && !rst)  return 1;
        return 0;
    endfunction

    // R3 / R4 per-cycle monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_owner != 2'b00 && owner != 2'b00 && owner != prev_owner) begin
                gap_viol++;
                $display("FAIL R3 direct handover actual=%0d expected=0 (from %0d)", owner, prev_owner);
            end
            if (ext_grant && (int_drv_en || ctrl_status_n)) begin
                gap_viol++;
                $display("FAIL R4 grant with drivers/status actual=%0d expected=0", {int_drv_en, ctrl_status_n});
            end
            prev_owner = owner;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        // R9 reset state
        chk(owner == 2'b00, "R9 owner", owner, 0);
        chk(int_drv_en == 1'b0, "R9 drv", int_drv_en, 0);
        chk(ext_grant == 1'b0, "R9 grant", ext_grant, 0);
        chk(hold_fpga_n == 1'b1, "R9 hold_n", hold_fpga_n, 1);
        chk(ctrl_status_n == 1'b1, "R9 status_n", ctrl_status_n, 1);
        rst_n = 1'b1;
        wait_neg(2);
        mon_on = 1'b1;

        // R1 R2 R3 R4 R7: all ordered pairs of input combinations
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int eo;
                apply(4'(a));
                wait_neg(SETTLE);
                apply(4'(b));
                wait_neg(SETTLE);
                eo = exp_owner(4'(b), 1'b0);
                chk(owner == 2'(eo), "R1 settled owner", owner, eo);
                chk(int_drv_en == (eo == 1 || eo == 2), "R4 drv enable", int_drv_en, int'(eo == 1 || eo == 2));
                chk(ext_grant == (eo == 3), "R2 ext grant", ext_grant, int'(eo == 3));
                chk(ctrl_status_n == !b[2], "R7 status", ctrl_status_n, int'(!b[2]));
            end
        end

        // R8 R5: hold under configuration ownership
        apply(4'b1000);
        wait_neg(SETTLE);
        chk(owner == 2'b01, "R5 pre cfg owner", owner, 1);
        jtag_pend_upd = 1'b1;
        wait_neg(1);
        chk(hold_fpga_n == 1'b1, "R8 hold after edge1", hold_fpga_n, 1);
        wait_neg(1);
        chk(hold_fpga_n == 1'b1, "R8 hold after edge2", hold_fpga_n, 1);
        wait_neg(1);
        chk(hold_fpga_n == 1'b0, "R8 hold after edge3", hold_fpga_n, 0);
        jtag_pend_upd = 1'b0;
        wait_neg(SETTLE);
        chk(ctrl_status_n == 1'b0, "R5 status low", ctrl_status_n, 0);
        chk(owner == 2'b00, "R5 cfg ends", owner, 0);
        ext_req = 1'b1;
        wait_neg(SETTLE);
        chk(owner == 2'(exp_owner(4'b1010, 1'b1)), "R5 ext owner under hold", owner, 3);
        chk(ext_grant == 1'b1, "R5 ext grant under hold", ext_grant, 1);

        // R6: release
        jtag_init_upd = 1'b1;
        wait_neg(4);
        jtag_init_upd = 1'b0;
        wait_neg(SETTLE);
        chk(hold_fpga_n == 1'b1, "R6 released", hold_fpga_n, 1);
        chk(ext_grant == 1'b0, "R6 grant dropped", ext_grant, 0);
        chk(owner == 2'b01, "R6 cfg resumes", owner, 1);

        // R6: init with no hold has no effect
        jtag_init_upd = 1'b1;
        wait_neg(4);
        jtag_init_upd = 1'b0;
        wait_neg(SETTLE);
        chk(hold_fpga_n == 1'b1, "R6 init ignored", hold_fpga_n, 1);
        chk(owner == 2'b01, "R6 owner kept", owner, 1);

        // R5: both strobes together set the hold
        jtag_pend_upd = 1'b1;
        jtag_init_upd = 1'b1;
        wait_neg(4);
        jtag_pend_upd = 1'b0;
        jtag_init_upd = 1'b0;
        wait_neg(SETTLE);
        chk(hold_fpga_n == 1'b0, "R5 simultaneous strobes", hold_fpga_n, 0);
        // R2: JTAG beats external while held
        jtag_isp_active = 1'b1;
        wait_neg(SETTLE);
        chk(owner == 2'b10, "R2 jtag over ext", owner, 2);
        chk(ext_grant == 1'b0, "R2 no ext during isp", ext_grant, 0);

        chk(gap_viol == 0, "R3 monitor violations", gap_viol, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule